// File: doc/BRIEF.md
# Four-channel double-ranked DAC code register front end

This block holds the digital codes of a four-channel, 8-bit digital-to-analog converter. A host places a code on an 8-bit parallel bus, picks a channel with a 2-bit address and pulls an active-low write strobe. While the strobe stays low, the input register of the chosen channel follows the bus. When the strobe rises, the register keeps the value it last captured. A second rank, one register per channel, feeds the converter codes. A level-sensitive transfer control governs it.

Holding the transfer control low makes the second rank see-through, so each output code tracks its input register. Raising it freezes all four outputs. Lowering it again moves every input register into the outputs in the same cycle, so all channels change together. A shutdown level clears the per-channel output-enable flags without touching any stored code, so the old codes come back when shutdown ends. A synchronous active-high reset clears both ranks.

Both ranks are clocked registers with a combinational see-through path. A level seen at the ports acts in the same cycle, and a value is held from the last rising clock edge at which its level was active.

Top module: `dacq_front`

## Requirements
- R1: While reset is high, and after the clock edge at which it is sampled high, all four output codes read 8'h00. With shutdown low, all four output-enable bits read 1 after reset.
- R2: Address value 0 selects channel A (code bits 7:0). Value 1 selects B (15:8), value 2 selects C (23:16) and value 3 selects D (31:24).
- R3: While the write strobe is low and the transfer control is low, the selected channel's output code equals the data bus in the same cycle. Unselected channels keep their codes.
- R4: After the write strobe rises, the selected input register keeps the bus value that was present at the last rising clock edge while the strobe was low.
- R5: While the transfer control is high, no output code changes, whatever writes take place.
- R6: When the transfer control goes low, all four output codes take their input register values in the same cycle.
- R7: When the transfer control rises, each output holds the value it showed at the clock edge where the control was first sampled high.
- R8: While shutdown is high, all four output-enable bits are 0 and the stored codes are unchanged. When shutdown goes low, the enables return to 1 and the same codes are shown.
- R9: Data bus bit 7 maps to the most significant bit of the channel code and bit 0 maps to its least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 8 | Parallel code bus, bit 7 most significant |
| addr_i | input | 2 | Channel select (0=A, 1=B, 2=C, 3=D) |
| wr_n_i | input | 1 | Active-low level write strobe |
| xfer_n_i | input | 1 | Transfer control. Low makes the output rank see-through |
| sdn_i | input | 1 | Shutdown request, active high |
| code_o | output | 32 | Four channel codes, channel A in bits 7:0 |
| oe_o | output | 4 | Per-channel output enable, bit 0 is channel A |

## Verification
The hardest situation to reach is the edge where the transfer control rises while a write is still in progress. There the output rank must keep the value seen at that edge, while the input rank goes on following the bus. The stimulus reaches it by raising the control and changing the bus in the same cycle with the strobe held low. It then lowers the control later and checks that the newer input value appears on all channels together. A write made during shutdown is checked in the same way: the bench confirms the code changed underneath, and that the enables come back once shutdown ends.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

    localparam int unsigned DQ_CHANNELS = 4;
    localparam int unsigned DQ_CODE_W   = 8;
    localparam int unsigned DQ_ADDR_W   = $clog2(DQ_CHANNELS);

    typedef logic [DQ_CODE_W-1:0] dq_code_t;

    // Write request as seen by one channel
    typedef struct packed {
        logic     wen;
        dq_code_t data;
    } dq_wreq_t;

    // State of one channel pair
    typedef struct packed {
        dq_code_t in_q;
        dq_code_t out_q;
    } dq_pair_t;

    function automatic dq_code_t dq_pick(input logic sel, input dq_code_t a,
                                         input dq_code_t b);
        return sel ? a : b;
    endfunction

endpackage

// File: rtl/dacq_decode.sv
module dacq_decode #(
    parameter int unsigned NCH = dacq_pkg::DQ_CHANNELS,
    parameter int unsigned AW  = dacq_pkg::DQ_ADDR_W
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [NCH-1:0] sel
);
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            sel[i] = en && (addr == AW'(i));
        end
    end
endmodule

// File: rtl/dacq_chan.sv
module dacq_chan
    import dacq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dq_wreq_t wreq,
    input  logic     xfer_n,
    output dq_code_t code
);
    dq_pair_t st_q;
    dq_pair_t st_d;
    dq_code_t in_view;
    dq_code_t out_view;

    // First rank: see-through while selected
    always_comb begin
        in_view = rst ? '0 : dq_pick(wreq.wen, wreq.data, st_q.in_q);
    end

    // Second rank: see-through while transfer control is low
    always_comb begin
        out_view = rst ? '0 : dq_pick(xfer_n, st_q.out_q, in_view);
    end

    always_comb begin
        st_d.in_q  = in_view;
        st_d.out_q = out_view;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = out_view;
endmodule

// File: rtl/dacq_front.sv
module dacq_front
    import dacq_pkg::*;
#(
    parameter int unsigned NCH = DQ_CHANNELS,
    parameter int unsigned CW  = DQ_CODE_W,
    localparam int unsigned AW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     data_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              wr_n_i,
    input  logic              xfer_n_i,
    input  logic              sdn_i,
    output logic [NCH*CW-1:0] code_o,
    output logic [NCH-1:0]    oe_o
);
    logic [NCH-1:0] sel;

    dacq_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .en   (!wr_n_i && !rst),
        .addr (addr_i),
        .sel  (sel)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dq_wreq_t wreq;
        dq_code_t code;
        assign wreq.wen  = sel[g];
        assign wreq.data = dq_code_t'(data_i);

        dacq_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .wreq   (wreq),
            .xfer_n (xfer_n_i),
            .code   (code)
        );

        assign code_o[g*CW +: CW] = CW'(code);
        assign oe_o[g]            = !sdn_i;
    end
endmodule

// File: rtl/dacq_front_chk.sv
module dacq_front_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 8,
    parameter int unsigned AW  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [CW-1:0]     data_i,
    input logic [AW-1:0]     addr_i,
    input logic              wr_n_i,
    input logic              xfer_n_i,
    input logic              sdn_i,
    input logic [NCH*CW-1:0] code_o,
    input logic [NCH-1:0]    oe_o
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && xfer_n_i) |-> (code_o == '0));

    p_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_n_i && !xfer_n_i) |-> (code_o[addr_i*CW +: CW] == data_i));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_n_i && !$past(wr_n_i) && !xfer_n_i && !$past(rst))
        |-> (code_o[$past(addr_i)*CW +: CW] == $past(data_i)));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (xfer_n_i && $past(xfer_n_i) && !$past(rst)) |-> $stable(code_o));

    p_resume_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(sdn_i) && xfer_n_i && $past(xfer_n_i) && !$past(rst))
        |-> ($stable(code_o) && (oe_o == '1)));
endmodule

bind dacq_front dacq_front_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .data_i   (data_i),
    .addr_i   (addr_i),
    .wr_n_i   (wr_n_i),
    .xfer_n_i (xfer_n_i),
    .sdn_i    (sdn_i),
    .code_o   (code_o),
    .oe_o     (oe_o)
);

// File: tb/test_dacq_front.sv
`timescale 1ns/1ps
module test_dacq_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  data = 8'h00;
    logic [1:0]  addr = 2'd0;
    logic        wr_n = 1'b1;
    logic        xfer_n = 1'b0;
    logic        sdn = 1'b0;
    logic [31:0] code;
    logic [3:0]  oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] in_m [4];
    logic [7:0] dac_m [4];

    always #2.5 clk = ~clk;

    dacq_front i_dacq_front (
        .clk(clk), .rst(rst), .data_i(data), .addr_i(addr), .wr_n_i(wr_n),
        .xfer_n_i(xfer_n), .sdn_i(sdn), .code_o(code), .oe_o(oe)
    );

    function automatic logic [7:0] m_in(int i);
        if (rst) return 8'h00;
        if (!wr_n && int'(addr) == i) return data;
        return in_m[i];
    endfunction

    function automatic logic [7:0] m_out(int i);
        if (rst) return 8'h00;
        return xfer_n ? dac_m[i] : m_in(i);
    endfunction

    function automatic logic [31:0] m_all();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) v[i*8 +: 8] = m_out(i);
        return v;
    endfunction

    always @(posedge clk) begin
        logic [7:0] ni [4];
        logic [7:0] nd [4];
        for (int i = 0; i < 4; i++) begin
            ni[i] = m_in(i);
            nd[i] = m_out(i);
        end
        for (int i = 0; i < 4; i++) begin
            in_m[i]  = ni[i];
            dac_m[i] = nd[i];
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (!rst) begin
            string tag;
            tag = sdn ? "R8" : (xfer_n ? "R5" : "R3");
            chk({tag, " model codes"}, code, m_all());
            chk("R8 model enables", {28'h0, oe}, {28'h0, {4{!sdn}}});
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout exp finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        chk("R1 codes after reset", code, 32'h0);
        chk("R1 enables after reset", {28'h0, oe}, 32'hf);

        // R2 / R3: each address with the output rank see-through
        for (int a = 0; a < 4; a++) begin
            tick();
            wr_n = 1'b0; addr = 2'(a); data = 8'(8'h11 * (a + 1));
            @(negedge clk);
            chk("R3 follow same cycle", {24'h0, code[a*8 +: 8]}, {24'h0, data});
        end
        tick(); wr_n = 1'b1;
        @(negedge clk);
        chk("R2 channel placement", code, 32'h44332211);

        // R4: hold after strobe rises
        tick(); wr_n = 1'b0; addr = 2'd1; data = 8'h5A;
        tick(); data = 8'hA5;
        @(negedge clk);
        chk("R3 follow bus change", {24'h0, code[15:8]}, 32'hA5);
        tick(); wr_n = 1'b1; data = 8'hFF;
        @(negedge clk);
        chk("R4 hold after strobe", {24'h0, code[15:8]}, 32'hA5);

        // R9: bit order
        tick(); wr_n = 1'b0; addr = 2'd0; data = 8'h80;
        @(negedge clk);
        chk("R9 msb position", {31'h0, code[7]}, 32'h1);
        chk("R9 low bits", {25'h0, code[6:0]}, 32'h0);
        tick(); wr_n = 1'b1;

        // R5 / R6: writes with transfer high, then simultaneous update
        tick(); xfer_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            tick(); wr_n = 1'b0; addr = 2'(a); data = 8'(8'hC0 + a);
            @(negedge clk);
            chk("R5 frozen during write", code, 32'h4433A580);
        end
        tick(); wr_n = 1'b1;
        @(negedge clk);
        chk("R5 frozen after writes", code, 32'h4433A580);
        tick(); xfer_n = 1'b0;
        @(negedge clk);
        chk("R6 all channels together", code, 32'hC3C2C1C0);

        // R7: transfer rises mid-write
        tick(); wr_n = 1'b0; addr = 2'd2; data = 8'h7E;
        @(negedge clk);
        chk("R3 channel C follow", {24'h0, code[23:16]}, 32'h7E);
        tick(); xfer_n = 1'b1; data = 8'h01;
        @(negedge clk);
        chk("R7 held at rise", {24'h0, code[23:16]}, 32'h7E);
        tick(); wr_n = 1'b1;
        @(negedge clk);
        chk("R7 still held", code, 32'hC37EC1C0);
        tick(); xfer_n = 1'b0;
        @(negedge clk);
        chk("R6 late input shown", code, 32'hC301C1C0);

        // R8: shutdown keeps contents
        tick(); sdn = 1'b1;
        @(negedge clk);
        chk("R8 enables off", {28'h0, oe}, 32'h0);
        chk("R8 codes intact", code, 32'hC301C1C0);
        tick(); wr_n = 1'b0; addr = 2'd3; data = 8'h99;
        @(negedge clk);
        chk("R8 write in shutdown", {24'h0, code[31:24]}, 32'h99);
        tick(); wr_n = 1'b1; sdn = 1'b0;
        @(negedge clk);
        chk("R8 enables back", {28'h0, oe}, 32'hf);
        chk("R8 codes back", code, 32'h9901C1C0);

        // R1: reset in mid operation
        tick(); rst = 1'b1;
        @(negedge clk);
        chk("R1 codes during reset", code, 32'h0);
        tick(); rst = 1'b0; xfer_n = 1'b1;
        @(negedge clk);
        chk("R1 codes after second reset", code, 32'h0);
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule